// File: doc/BRIEF.md
# Line-Clock Divider Control Bank

This block is the control store for a video line-clock generator, plus the programmable line counter that the stored ratio drives. A host reaches it through a plain synchronous register port made of an address, write data, a write strobe and a combinational read-data return. It holds several things:

- a 12-bit line divide ratio, split over two byte registers;
- a two-bit clock-range select;
- a test bit;
- a read-only revision byte;
- six reserved configuration bytes, each with a fixed reset value.

The upper eight bits of the ratio are written into a staging byte. That byte has no effect until the lower nibble is written, and then all twelve bits are committed in one step. The counter advances once for each cycle in which the pixel enable is high. It emits a one-cycle line pulse every (ratio + 1) enabled cycles. The counter picks up a newly committed ratio only at a line boundary, so no line is ever cut short. If the committed ratio is below the legal floor of 221, the counter treats it as 221, but the registers still read back the raw value.

The register port has no flow control: every strobe is taken in the cycle it is presented. All other pins are plain levels or pulses.

Top module: `linediv_ctrl`

## Requirements
- R1: After reset the registers read as follows. Address 0x01 reads 0x69 and address 0x02 reads 0xD0, which together give a ratio of 1693. Address 0x03 reads 0x20. Addresses 0x22, 0x23 and 0x24 read 0x00. Address 0x25 reads 0xF0, 0x26 reads 0xFF and 0x27 reads 0x0F. The output `active_ratio` is 1693.
- R2: A write to address 0x01 alone changes only the staging byte. Address 0x01 reads the new value, while `active_ratio` and the line period stay unchanged.
- R3: A write to address 0x02 commits {staging byte, wdata[7:4]} as the 12-bit ratio. `active_ratio` shows the new value from the cycle after the strobe.
- R4: `line_pulse` is high for one cycle, one cycle after the enabled pixel cycle that completes a line. Each line spans exactly (effective ratio + 1) cycles with `pix_en` high. Cycles with `pix_en` low do not advance the count.
- R5: Address 0x00 reads the revision byte, 0x20 by default: the functional revision in bits 7:4 and the minor revision in bits 3:0. Writes to address 0x00 are ignored.
- R6: In address 0x03, bit 7 is the test bit and bits 6:5 are the range select. Both read back as written and drive `test_bit` and `range_sel`. Bits 4:0 read as zero.
- R7: A committed ratio below 221 makes the counter use 221, giving a period of 222. Addresses 0x01 and 0x02 still read the raw value that was written.
- R8: A ratio committed in the middle of a line does not change that line's length. The new ratio applies from the following line on.
- R9: Unmapped addresses read 0x00, and writes to them change no register. Bits 3:0 of address 0x02 read as zero.
- R10: The reserved bytes at 0x22 through 0x27 read back the full byte last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one write per high cycle |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pix_en | input | 1 | Pixel-time enable for the line counter |
| line_pulse | output | 1 | One-cycle line-boundary pulse |
| active_ratio | output | 12 | Committed raw divide ratio |
| range_sel | output | 2 | Clock-range select field |
| test_bit | output | 1 | Test control bit |

## Verification
A staging byte that leaks into the committed ratio shows up on `active_ratio` one cycle after the write to address 0x01. It also shows up as a line period that differs from the old one. A counter limit that is reloaded outside a boundary, or that escapes the clamp, shows up within one line: the number of enabled cycles between two `line_pulse` events no longer equals the expected value plus one. Decode errors in the register map appear at the first read of the affected address.

// File: rtl/linediv_pkg.sv
package linediv_pkg;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int RW = 12;

  localparam logic [AW-1:0] A_REV  = 8'h00;
  localparam logic [AW-1:0] A_HI   = 8'h01;
  localparam logic [AW-1:0] A_LO   = 8'h02;
  localparam logic [AW-1:0] A_CFG  = 8'h03;
  localparam logic [AW-1:0] A_RSV0 = 8'h22;
  localparam int NRSV = 6;

  localparam logic [RW-1:0] RATIO_RST = 12'd1693;
  localparam logic [RW-1:0] RATIO_MIN = 12'd221;
  localparam logic [1:0]    RANGE_RST = 2'b01;

  function automatic logic [DW-1:0] rsv_reset(input int idx);
    case (idx)
      3:       return 8'hF0;
      4:       return 8'hFF;
      5:       return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [RW-1:0] clamp_ratio(input logic [RW-1:0] r);
    return (r < RATIO_MIN) ? RATIO_MIN : r;
  endfunction
endpackage

// File: rtl/linediv_regfile.sv
module linediv_regfile
  import linediv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  input  logic               reg_we,
  output logic [DW-1:0]      stage_hi,
  output logic [RW-1:0]      commit_q,
  output logic               cfg_test,
  output logic [1:0]         cfg_range,
  output logic [NRSV*DW-1:0] rsv_flat
);
  localparam int LO_W = RW - DW;

  logic wr_hi, wr_lo, wr_cfg;
  assign wr_hi  = reg_we && (reg_addr == A_HI);
  assign wr_lo  = reg_we && (reg_addr == A_LO);
  assign wr_cfg = reg_we && (reg_addr == A_CFG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_hi <= RATIO_RST[RW-1:LO_W];
      commit_q <= RATIO_RST;
    end else begin
      if (wr_hi) stage_hi <= reg_wdata;
      if (wr_lo) commit_q <= {stage_hi, reg_wdata[DW-1 -: LO_W]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_test  <= 1'b0;
      cfg_range <= RANGE_RST;
    end else if (wr_cfg) begin
      cfg_test  <= reg_wdata[7];
      cfg_range <= reg_wdata[6:5];
    end
  end

  for (genvar i = 0; i < NRSV; i++) begin : g_rsv
    logic wr_i;
    assign wr_i = reg_we && (reg_addr == A_RSV0 + AW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)    rsv_flat[i*DW +: DW] <= rsv_reset(i);
      else if (wr_i) rsv_flat[i*DW +: DW] <= reg_wdata;
    end
  end

  // R2: staging write leaves the committed ratio alone
  p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_HI) |=> $stable(commit_q));
  // R3: low nibble lands from the write data
  p_commit_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_LO) |=> (commit_q[3:0] == $past(reg_wdata[7:4])));
  // R3: commit changes only on a low-nibble write
  p_commit_only_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_LO) |=> $stable(commit_q));
endmodule

// File: rtl/linediv_rdmux.sv
module linediv_rdmux
  import linediv_pkg::*;
#(
  parameter logic [DW-1:0] REV = 8'h20
) (
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      stage_hi,
  input  logic [RW-1:0]      commit_q,
  input  logic               cfg_test,
  input  logic [1:0]         cfg_range,
  input  logic [NRSV*DW-1:0] rsv_flat,
  output logic [DW-1:0]      reg_rdata
);
  localparam int LO_W = RW - DW;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_REV) begin
      reg_rdata = REV;
    end else if (reg_addr == A_HI) begin
      reg_rdata = stage_hi;
    end else if (reg_addr == A_LO) begin
      reg_rdata = {commit_q[LO_W-1:0], {(DW-LO_W){1'b0}}};
    end else if (reg_addr == A_CFG) begin
      reg_rdata = {cfg_test, cfg_range, 5'b0};
    end else begin
      for (int i = 0; i < NRSV; i++) begin
        if (reg_addr == A_RSV0 + AW'(i)) reg_rdata = rsv_flat[i*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/linediv_linectr.sv
module linediv_linectr
  import linediv_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic [RW-1:0] ratio_in,
  output logic          line_pulse
);
  logic [RW-1:0] cnt_q, lim_q;
  logic          wrap;

  assign wrap = pix_en && (cnt_q == lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      lim_q      <= clamp_ratio(RATIO_RST);
      line_pulse <= 1'b0;
    end else begin
      line_pulse <= wrap;
      if (wrap) begin
        cnt_q <= '0;
        lim_q <= clamp_ratio(ratio_in);
      end else if (pix_en) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R7: the limit never drops under the floor
  p_lim_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lim_q >= RATIO_MIN);
  // R4: count stays within the current line
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);
  // R4: a pulse follows an enabled cycle
  p_pulse_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    line_pulse |-> $past(pix_en));
  // R8: limit is reloaded only at a boundary
  p_lim_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_en && cnt_q == lim_q) |=> $stable(lim_q));
  // R4: disabled cycle freezes the count
  p_cnt_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(cnt_q));
endmodule

// File: rtl/linediv_ctrl.sv
module linediv_ctrl
  import linediv_pkg::*;
#(
  parameter logic [7:0] REV = 8'h20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  input  logic        reg_we,
  output logic [7:0]  reg_rdata,
  input  logic        pix_en,
  output logic        line_pulse,
  output logic [11:0] active_ratio,
  output logic [1:0]  range_sel,
  output logic        test_bit
);
  logic [DW-1:0]      stage_hi;
  logic [RW-1:0]      commit_q;
  logic               cfg_test;
  logic [1:0]         cfg_range;
  logic [NRSV*DW-1:0] rsv_flat;

  linediv_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .stage_hi  (stage_hi),
    .commit_q  (commit_q),
    .cfg_test  (cfg_test),
    .cfg_range (cfg_range),
    .rsv_flat  (rsv_flat)
  );

  linediv_rdmux #(.REV(REV)) u_rd (
    .reg_addr  (reg_addr),
    .stage_hi  (stage_hi),
    .commit_q  (commit_q),
    .cfg_test  (cfg_test),
    .cfg_range (cfg_range),
    .rsv_flat  (rsv_flat),
    .reg_rdata (reg_rdata)
  );

  linediv_linectr u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_en     (pix_en),
    .ratio_in   (commit_q),
    .line_pulse (line_pulse)
  );

  assign active_ratio = commit_q;
  assign range_sel    = cfg_range;
  assign test_bit     = cfg_test;

  // R4: pulses never come back to back, since a line is longer than one cycle
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    line_pulse |=> !line_pulse);
endmodule

// File: tb/linediv_ctrl_test.sv
`timescale 1ns/1ps
module linediv_ctrl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0;
  logic        reg_we = 0;
  logic [7:0]  reg_rdata;
  logic        pix_en = 0;
  logic        line_pulse;
  logic [11:0] active_ratio;
  logic [1:0]  range_sel;
  logic        test_bit;

  int n_cmp = 0;
  int n_bad = 0;
  int duty = 100;
  int pulses = 0;
  int since = 0;
  int last_iv = 0;
  bit done = 0;

  always #2 clk = ~clk;

  linediv_ctrl uut (.*);

  function automatic int eff_period(input int raw);
    return ((raw < 221) ? 221 : raw) + 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // pixel enable driver
  always @(posedge clk) begin
    #1 pix_en <= ($urandom % 100) < duty;
  end

  // line monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (line_pulse) begin
        last_iv = since;
        since = 0;
        pulses++;
      end
      if (pix_en) since++;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #0.5 v = reg_rdata;
  endtask

  task automatic wait_pulse();
    int p0 = pulses;
    while (pulses == p0) @(negedge clk);
  endtask

  // commit mid-line, old period holds for this line, new one after
  task automatic ratio_step(input string req, input int old_raw, input int new_raw);
    int v;
    wait_pulse();
    repeat (30) @(posedge clk);
    wr(8'h01, 8'(new_raw >> 4));
    wr(8'h02, 8'((new_raw & 15) << 4));
    check("R3", int'(active_ratio), new_raw);
    wait_pulse();
    check("R8", last_iv, eff_period(old_raw));
    wait_pulse();
    check(req, last_iv, eff_period(new_raw));
    rd(8'h01, v); check("R7", v, new_raw >> 4);
    rd(8'h02, v); check("R7", v, (new_raw & 15) << 4);
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int v, cur;
    logic [7:0] rsv_m [6];
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(8'h01, v); check("R1", v, 8'h69);
    rd(8'h02, v); check("R1", v, 8'hD0);
    rd(8'h03, v); check("R1", v, 8'h20);
    check("R1", int'(active_ratio), 1693);
    rsv_m = '{8'h00, 8'h00, 8'h00, 8'hF0, 8'hFF, 8'h0F};
    for (int i = 0; i < 6; i++) begin
      rd(8'h22 + 8'(i), v); check("R1", v, rsv_m[i]);
    end

    // R5 revision read-only
    rd(8'h00, v); check("R5", v, 8'h20);
    wr(8'h00, 8'h5A);
    rd(8'h00, v); check("R5", v, 8'h20);

    // R6 config field
    wr(8'h03, 8'hFF);
    rd(8'h03, v); check("R6", v, 8'hE0);
    check("R6", int'(range_sel), 3); check("R6", int'(test_bit), 1);
    wr(8'h03, 8'h40);
    rd(8'h03, v); check("R6", v, 8'h40);
    check("R6", int'(range_sel), 2); check("R6", int'(test_bit), 0);
    wr(8'h03, 8'h80);

    // R9 unmapped
    wr(8'h10, 8'hAA);
    rd(8'h10, v); check("R9", v, 0);
    rd(8'h21, v); check("R9", v, 0);
    rd(8'h28, v); check("R9", v, 0);
    rd(8'h03, v); check("R9", v, 8'h80);

    // R4 reset period
    wait_pulse(); wait_pulse();
    check("R4", last_iv, 1694);

    // R2 staging alone
    wr(8'h01, 8'h12);
    rd(8'h01, v); check("R2", v, 8'h12);
    check("R2", int'(active_ratio), 1693);
    wait_pulse(); wait_pulse();
    check("R2", last_iv, 1694);

    // directed ratio steps
    duty = 100;
    ratio_step("R4", 1693, 221); cur = 221;
    duty = 60;
    ratio_step("R7", cur, 5); cur = 5;
    ratio_step("R7", cur, 220); cur = 220;
    duty = 100;
    ratio_step("R4", cur, 4095); cur = 4095;
    ratio_step("R4", cur, 222); cur = 222;

    // random ratios and duty
    for (int k = 0; k < 8; k++) begin
      int nr = ($urandom % 10 == 0) ? int'($urandom % 221) : 221 + int'($urandom % 480);
      duty = 40 + int'($urandom % 61);
      ratio_step("R4", cur, nr); cur = nr;
    end

    // R10 reserved random writes
    for (int k = 0; k < 20; k++) begin
      int idx = int'($urandom % 6);
      logic [7:0] d = 8'($urandom);
      wr(8'h22 + 8'(idx), d);
      rsv_m[idx] = d;
      rd(8'h22 + 8'(idx), v); check("R10", v, d);
    end
    for (int i = 0; i < 6; i++) begin
      rd(8'h22 + 8'(i), v); check("R10", v, rsv_m[i]);
    end

    // R9 low nibble of 0x02 reads zero
    wr(8'h02, 8'h3F);
    rd(8'h02, v); check("R9", v, 8'h30);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    done = 1;
    $finish;
  end
endmodule